// File: doc/BRIEF.md
# Master-ID Permission Rule Checker

This block decides, in a single combinational pass, whether one bus transaction may go ahead. The caller provides several inputs alongside a valid strobe:

- the 32-bit permission word that covers the addressed region;
- the 10-bit master ID of the requester;
- a write flag and a secure flag;
- a table of 20 master-ID entries;
- two parity-check enables.

The block returns an allow bit and five single-cycle error flags. A surrounding protection unit can use these to pass or block the access and to log the cause.

The permission word chooses which table entries apply to the region and whether non-secure requesters are welcome. It also carries four grouped parity bits. Each table entry holds an ID, a compare mask, a read-only marker and its own parity bit. All entries are evaluated in parallel. A prefix network then makes the result identical to a scan from entry 0 upward that stops at the first entry granting access. An entry that matches but fails a test raises its own flag, and the scan continues.

Top module: `mid_rule_checker`

## Requirements
- R1: With valid_i low, allow_o and every error flag are 0 whatever the other inputs hold.
- R2: The permission word's bits 31:28 are parity bits P3..P0. Pi is the XOR of word bits 5i+4..5i for i=0..2, and P3 is the XOR of bits 19:15 and bit 27. With aper_par_en_i set and any mismatch, the transaction is denied, err_aper_par_o is 1 and all other flags are 0.
- R3: With aper_par_en_i clear, bits 31:28 of the permission word have no effect on any output.
- R4: Permission bit i (i in 0..19) enables table entry i. An enabled entry matches when (entry_id & mask) equals (txn_id & mask). Entry i sits at id_table_i[32i+31:32i], with ID in bits 9:0 and mask in bits 25:16.
- R5: Entry bit 31 is its parity bit and must equal the XOR of entry bits 30, 25:16 and 9:0. With id_par_en_i set, a matching entry with bad parity raises err_id_par_o and is skipped.
- R6: Entry bit 30 marks the entry read-only. A write that matches it raises err_ro_o and skips the entry; a read passes this test.
- R7: When txn_secure_i is 0 and permission bit 27 is 0, a matching entry raises err_tz_o and is skipped. With bit 27 set, non-secure access passes.
- R8: A matching entry's tests run in the order parity, read-only, secure. Only the first failing test raises a flag for that entry.
- R9: When no enabled entry matches, err_miss_o is 1 and allow_o is 0.
- R10: allow_o is 1 when some enabled, matching entry passes every test. Failures of entries with a higher index than the lowest passing entry raise no flag.
- R11: With id_par_en_i clear, entry bit 31 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid_i | input | 1 | Qualifies the transaction for this cycle |
| perm_word_i | input | 32 | Permission word of the addressed region |
| txn_id_i | input | 10 | Master ID of the transaction |
| txn_write_i | input | 1 | 1 for write, 0 for read |
| txn_secure_i | input | 1 | 1 for a secure transaction |
| id_table_i | input | 640 | 20 packed 32-bit master-ID entries, entry 0 lowest |
| aper_par_en_i | input | 1 | Enables permission-word parity check |
| id_par_en_i | input | 1 | Enables entry parity check |
| allow_o | output | 1 | Transaction may proceed |
| err_aper_par_o | output | 1 | Permission-word parity error |
| err_id_par_o | output | 1 | Entry parity error on a matching entry |
| err_ro_o | output | 1 | Write to a read-only entry |
| err_tz_o | output | 1 | Non-secure access refused |
| err_miss_o | output | 1 | No enabled entry matched |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:

- **Two matching entries.** The lower one fails and the higher one passes. A design that gated flags on the wrong side of the priority would either drop the lower entry's flag or report failures from entries above the winner.
- **One entry failing several tests at once.** This exposes a wrong test order, which shows up as a read-only or secure flag where a parity flag belongs.
- **Disabled parity checks.** Deliberately corrupted parity bits must then change nothing.
- **A permission-word parity error with a matching, valid entry.** A design that did not treat the error as final would grant access or report a miss alongside the error.
- **Masked compares.** Ignored ID bits differ between the entry and the requester, and a design that compared unmasked bits would report a miss.

// File: rtl/mid_rule_pkg.sv
package mid_rule_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned ID_W       = 10;
  localparam int unsigned NUM_ENTRY  = 20;
  localparam int unsigned GROUP_W    = 5;
  localparam int unsigned NUM_GROUP  = 4;

  // Permission word positions the decode depends on
  localparam int unsigned NS_OK_BIT  = 27;
  localparam int unsigned PAR_LSB    = 28;

  // Entry field positions
  localparam int unsigned MASK_LSB   = 16;
  localparam int unsigned RO_BIT     = 30;
  localparam int unsigned EPAR_BIT   = 31;

  typedef struct packed {
    logic            par;
    logic            ro;
    logic [ID_W-1:0] mask;
    logic [ID_W-1:0] id;
  } id_entry_t;

  typedef struct packed {
    logic par;
    logic ro;
    logic tz;
  } entry_fail_t;

  function automatic id_entry_t unpack_entry(input logic [WORD_W-1:0] raw);
    id_entry_t e;
    e.par  = raw[EPAR_BIT];
    e.ro   = raw[RO_BIT];
    e.mask = raw[MASK_LSB +: ID_W];
    e.id   = raw[ID_W-1:0];
    return e;
  endfunction
endpackage

// File: rtl/mid_rule_word_parity.sv
module mid_rule_word_parity
  import mid_rule_pkg::*;
#(
  parameter int unsigned GROUPS = NUM_GROUP,
  parameter int unsigned GW     = GROUP_W
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              check_en_i,
  output logic              word_ok_o
);
  localparam int unsigned LAST = GROUPS - 1;

  logic [GROUPS-1:0] calc;

  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      if (g == LAST) begin : g_last
        assign calc[g] = ^word_i[g*GW +: GW] ^ word_i[NS_OK_BIT];
      end else begin : g_mid
        assign calc[g] = ^word_i[g*GW +: GW];
      end
    end
  endgenerate

  assign word_ok_o = !check_en_i || (calc == word_i[PAR_LSB +: GROUPS]);

  always_comb begin
    if (!check_en_i) begin
      p_par_off_ok_r3: assert (word_ok_o) else $error("R3 parity disabled but word rejected");
    end
  end
endmodule

// File: rtl/mid_rule_entry.sv
module mid_rule_entry
  import mid_rule_pkg::*;
(
  input  logic [WORD_W-1:0] raw_i,
  input  logic              enable_i,
  input  logic [ID_W-1:0]   txn_id_i,
  input  logic              write_i,
  input  logic              secure_i,
  input  logic              ns_ok_i,
  input  logic              par_en_i,
  output logic              hit_o,
  output logic              pass_o,
  output entry_fail_t       fail_o
);
  id_entry_t ent;
  logic      par_bad;
  logic      ro_bad;
  logic      tz_bad;

  always_comb begin
    ent     = unpack_entry(raw_i);
    hit_o   = enable_i && ((ent.id & ent.mask) == (txn_id_i & ent.mask));
    par_bad = par_en_i && (ent.par != (^{ent.ro, ent.mask, ent.id}));
    ro_bad  = ent.ro && write_i;
    tz_bad  = !secure_i && !ns_ok_i;

    fail_o.par = hit_o && par_bad;
    fail_o.ro  = hit_o && !par_bad && ro_bad;
    fail_o.tz  = hit_o && !par_bad && !ro_bad && tz_bad;
    pass_o     = hit_o && !par_bad && !ro_bad && !tz_bad;
  end

  always_comb begin
    p_one_outcome_r8: assert ($onehot0({pass_o, fail_o.par, fail_o.ro, fail_o.tz}))
      else $error("R8 entry has more than one outcome");
    if (!hit_o) begin
      p_nohit_quiet_r4: assert (!pass_o && fail_o == '0)
        else $error("R4 unmatched entry produced an outcome");
    end
  end
endmodule

// File: rtl/mid_rule_resolve.sv
module mid_rule_resolve
  import mid_rule_pkg::*;
#(
  parameter int unsigned N = NUM_ENTRY
) (
  input  logic [N-1:0] hit_i,
  input  logic [N-1:0] pass_i,
  input  logic [N-1:0] fpar_i,
  input  logic [N-1:0] fro_i,
  input  logic [N-1:0] ftz_i,
  output logic         any_hit_o,
  output logic         any_pass_o,
  output logic         par_o,
  output logic         ro_o,
  output logic         tz_o
);
  logic [N-1:0] shadowed;

  generate
    for (genvar i = 0; i < N; i++) begin : g_pre
      if (i == 0) begin : g_first
        assign shadowed[i] = 1'b0;
      end else begin : g_rest
        assign shadowed[i] = shadowed[i-1] | pass_i[i-1];
      end
    end
  endgenerate

  assign any_hit_o  = |hit_i;
  assign any_pass_o = |pass_i;
  assign par_o      = |(fpar_i & ~shadowed);
  assign ro_o       = |(fro_i  & ~shadowed);
  assign tz_o       = |(ftz_i  & ~shadowed);

  always_comb begin
    if (any_pass_o) begin
      p_pass_means_hit_r10: assert (any_hit_o) else $error("R10 pass without hit");
    end
  end
endmodule

// File: rtl/mid_rule_checker.sv
module mid_rule_checker
  import mid_rule_pkg::*;
#(
  parameter int unsigned N_ENT = NUM_ENTRY
) (
  input  logic                    valid_i,
  input  logic [WORD_W-1:0]       perm_word_i,
  input  logic [ID_W-1:0]         txn_id_i,
  input  logic                    txn_write_i,
  input  logic                    txn_secure_i,
  input  logic [N_ENT*WORD_W-1:0] id_table_i,
  input  logic                    aper_par_en_i,
  input  logic                    id_par_en_i,
  output logic                    allow_o,
  output logic                    err_aper_par_o,
  output logic                    err_id_par_o,
  output logic                    err_ro_o,
  output logic                    err_tz_o,
  output logic                    err_miss_o
);
  logic              word_ok;
  logic [N_ENT-1:0]  hit;
  logic [N_ENT-1:0]  pass;
  logic [N_ENT-1:0]  fpar;
  logic [N_ENT-1:0]  fro;
  logic [N_ENT-1:0]  ftz;
  logic              any_hit;
  logic              any_pass;
  logic              r_par;
  logic              r_ro;
  logic              r_tz;
  logic              live;

  mid_rule_word_parity u_wpar (
    .word_i     (perm_word_i),
    .check_en_i (aper_par_en_i),
    .word_ok_o  (word_ok)
  );

  generate
    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      entry_fail_t fl;
      mid_rule_entry u_ent (
        .raw_i    (id_table_i[i*WORD_W +: WORD_W]),
        .enable_i (perm_word_i[i]),
        .txn_id_i (txn_id_i),
        .write_i  (txn_write_i),
        .secure_i (txn_secure_i),
        .ns_ok_i  (perm_word_i[NS_OK_BIT]),
        .par_en_i (id_par_en_i),
        .hit_o    (hit[i]),
        .pass_o   (pass[i]),
        .fail_o   (fl)
      );
      assign fpar[i] = fl.par;
      assign fro[i]  = fl.ro;
      assign ftz[i]  = fl.tz;
    end
  endgenerate

  mid_rule_resolve #(.N(N_ENT)) u_res (
    .hit_i      (hit),
    .pass_i     (pass),
    .fpar_i     (fpar),
    .fro_i      (fro),
    .ftz_i      (ftz),
    .any_hit_o  (any_hit),
    .any_pass_o (any_pass),
    .par_o      (r_par),
    .ro_o       (r_ro),
    .tz_o       (r_tz)
  );

  assign live           = valid_i && word_ok;
  assign allow_o        = live && any_pass;
  assign err_aper_par_o = valid_i && !word_ok;
  assign err_id_par_o   = live && r_par;
  assign err_ro_o       = live && r_ro;
  assign err_tz_o       = live && r_tz;
  assign err_miss_o     = live && !any_hit;

  always_comb begin
    if (!valid_i) begin
      p_idle_quiet_r1: assert ({allow_o, err_aper_par_o, err_id_par_o, err_ro_o, err_tz_o, err_miss_o} == '0)
        else $error("R1 output active without valid");
    end
    if (err_aper_par_o) begin
      p_word_par_final_r2: assert (!allow_o && !err_id_par_o && !err_ro_o && !err_tz_o && !err_miss_o)
        else $error("R2 other outcome alongside word parity error");
    end
    if (err_miss_o) begin
      p_miss_alone_r9: assert (!allow_o && !err_id_par_o && !err_ro_o && !err_tz_o)
        else $error("R9 miss with entry outcome");
    end
  end
endmodule

// File: tb/mid_rule_checker_bench.sv
module mid_rule_checker_bench;
  localparam int NE = 20;

  logic clk;
  logic              valid;
  logic [31:0]       word;
  logic [9:0]        tid;
  logic              wr;
  logic              sec;
  logic [NE*32-1:0]  tab;
  logic              ap_en;
  logic              id_en;
  logic allow, e_ap, e_id, e_ro, e_tz, e_miss;

  int checks = 0;
  int failures = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  mid_rule_checker u_mid_rule_checker (
    .valid_i(valid), .perm_word_i(word), .txn_id_i(tid), .txn_write_i(wr),
    .txn_secure_i(sec), .id_table_i(tab), .aper_par_en_i(ap_en), .id_par_en_i(id_en),
    .allow_o(allow), .err_aper_par_o(e_ap), .err_id_par_o(e_id), .err_ro_o(e_ro),
    .err_tz_o(e_tz), .err_miss_o(e_miss)
  );

  function automatic logic [3:0] word_par(input logic [31:0] w);
    logic [3:0] p = '0;
    for (int b = 0; b < 20; b++) p[b/5] = p[b/5] ^ w[b];
    p[3] = p[3] ^ w[27];
    return p;
  endfunction

  function automatic logic [31:0] fix_word(input logic [31:0] w);
    return {word_par(w), w[27:0]};
  endfunction

  function automatic logic [31:0] mk_entry(input logic [9:0] id, input logic [9:0] m,
                                           input logic ro, input logic good);
    logic [31:0] e = '0;
    logic p = 1'b0;
    e[9:0] = id; e[25:16] = m; e[30] = ro;
    for (int b = 0; b < 31; b++) p = p ^ e[b];
    e[31] = good ? p : ~p;
    return e;
  endfunction

  // expected {allow, ap, idpar, ro, tz, miss} by sequential scan
  function automatic logic [5:0] model();
    logic a = 0, ip = 0, r = 0, t = 0, h = 0;
    logic [31:0] e;
    logic pb;
    if (!valid) return 6'b0;
    if (ap_en && (word[31:28] != word_par(word))) return 6'b010000;
    for (int i = 0; i < NE; i++) begin
      if (!word[i]) continue;
      e = tab[i*32 +: 32];
      if ((e[9:0] & e[25:16]) != (tid & e[25:16])) continue;
      h = 1;
      pb = ^{e[30], e[25:16], e[9:0]};
      if (id_en && (pb != e[31])) begin ip = 1; continue; end
      if (e[30] && wr) begin r = 1; continue; end
      if (!sec && !word[27]) begin t = 1; continue; end
      a = 1;
      break;
    end
    return {a, 1'b0, ip, r, t, !h};
  endfunction

  task automatic check(input string tag, input logic [5:0] exp);
    logic [5:0] got;
    #5;
    got = {allow, e_ap, e_id, e_ro, e_tz, e_miss};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic clear();
    @(negedge clk);
    valid = 1; word = '0; tid = '0; wr = 0; sec = 1; tab = '0; ap_en = 0; id_en = 0;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired got=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [5:0] exp;
    string tag;
    void'($urandom(32'd4711));
    clear();

    // R1: valid low gives nothing, even with a passing entry
    tab[0 +: 32] = mk_entry(10'h5, 10'h3ff, 0, 1);
    word = fix_word(32'h1 | (1 << 27)); tid = 10'h5; valid = 0;
    check("R1", 6'b000000);
    valid = 1;
    check("R10 simple allow", 6'b100000);

    // R2: bad word parity with enable, matching good entry present
    ap_en = 1; word = fix_word(32'h1 | (1 << 27)) ^ 32'h2000_0000;
    check("R2", 6'b010000);
    // R3: same corrupted word with check disabled
    ap_en = 0;
    check("R3", 6'b100000);

    // R4: masked compare ignores differing low bits; disabled entry ignored
    clear();
    tab[3*32 +: 32] = mk_entry(10'h2a0, 10'h3f0, 0, 1);
    tid = 10'h2a7; word = 32'h8 | (1 << 27);
    check("R4 masked", 6'b100000);
    word = 32'h0 | (1 << 27);
    check("R4 disabled", 6'b000001);

    // R5: bad entry parity checked; R11 ignored when disabled
    clear();
    tab[0 +: 32] = mk_entry(10'h11, 10'h3ff, 0, 0);
    tid = 10'h11; word = 32'h1 | (1 << 27); id_en = 1;
    check("R5", 6'b001000);
    id_en = 0;
    check("R11", 6'b100000);

    // R6: write to read-only, read passes
    clear();
    tab[0 +: 32] = mk_entry(10'h40, 10'h3ff, 1, 1);
    tid = 10'h40; word = 32'h1 | (1 << 27); wr = 1;
    check("R6 write", 6'b000100);
    wr = 0;
    check("R6 read", 6'b100000);

    // R7: non-secure refused then allowed by bit 27
    sec = 0; word = 32'h1;
    check("R7 refused", 6'b000010);
    word = 32'h1 | (1 << 27);
    check("R7 allowed", 6'b100000);

    // R8: entry failing parity, ro and secure only reports parity
    clear();
    tab[0 +: 32] = mk_entry(10'h7, 10'h3ff, 1, 0);
    tid = 10'h7; word = 32'h1; wr = 1; sec = 0; id_en = 1;
    check("R8 order", 6'b001000);
    id_en = 0;
    check("R8 order ro", 6'b000100);

    // R9: nothing matches
    clear();
    tab[0 +: 32] = mk_entry(10'h1, 10'h3ff, 0, 1);
    tid = 10'h2; word = 32'h1;
    check("R9", 6'b000001);

    // R10: lower fails, middle passes, higher fails (not reported)
    clear();
    tab[1*32 +: 32] = mk_entry(10'h9, 10'h3ff, 1, 1);
    tab[4*32 +: 32] = mk_entry(10'h9, 10'h3ff, 0, 1);
    tab[7*32 +: 32] = mk_entry(10'h9, 10'h3ff, 0, 0);
    tid = 10'h9; wr = 1; id_en = 1; word = 32'h92 | (1 << 27);
    check("R10 priority", 6'b100100);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      valid = ($urandom_range(0, 15) != 0);
      ap_en = $urandom_range(0, 1);
      id_en = $urandom_range(0, 1);
      wr = $urandom_range(0, 1);
      sec = $urandom_range(0, 1);
      tid = 10'($urandom_range(0, 7));
      for (int i = 0; i < NE; i++) begin
        logic [9:0] m;
        m = ($urandom_range(0, 2) == 0) ? 10'($urandom) : 10'h3ff;
        tab[i*32 +: 32] = mk_entry(10'($urandom_range(0, 7)), m,
                                   $urandom_range(0, 3) == 0, $urandom_range(0, 6) != 0);
      end
      word = {4'h0, 1'b0, 3'($urandom), 8'h0, 20'($urandom) & 20'($urandom)};
      word[27] = $urandom_range(0, 1);
      word = fix_word(word);
      if ($urandom_range(0, 6) == 0) word[28 + $urandom_range(0, 3)] ^= 1'b1;
      exp = model();
      if (!valid) tag = "R1";
      else if (exp[4]) tag = "R2";
      else if (exp[0]) tag = "R9";
      else if (exp[5]) tag = "R10";
      else tag = "R8";
      check(tag, exp);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule